// File: doc/BRIEF.md
# External Word-Clock Rate Meter

This block finds the sample rate of an external digital-audio word clock. It counts cycles of a 28.224 MHz reference clock between consecutive rising edges of the selected word clock. The count is a 10-bit tick value. Each word clock first passes through a two-flop synchronizer into the reference domain. Two word-clock inputs are available, and each one has its own clock-present and data-present flags.

The host picks one input and later freezes the live count, both through byte writes to a control port. It then reads the frozen tick count and a snapped standard rate. The frozen tick count is offered as one 10-bit output, and a host interface can split it into an upper 2-bit part and a lower 8-bit part.

The block does not divide. It compares the frozen tick count against fifteen tick bounds that are fixed when the design is built. Each bound is worked out from a rate threshold. The result is one of fifteen standard rates, or 0 when there is no usable clock.

Top module: `wclk_rate_meter`

## Requirements
- R1: After reset, tick_count, rate_code and rate_hz are all 0, and the primary input (A) is selected.
- R2: The live period is the number of reference cycles between two consecutive rising edges of the selected synchronized word clock. The first edge after reset, after a source change or after a stall only restarts counting and does not produce a period.
- R3: A write with sel_we high handles bits 1:0 of sel_wdata as follows.
  - If bit 0 is set, input A is selected. This also applies when bit 1 is set too.
  - If only bit 1 is set, input B is selected.
  - If neither bit is set, the selection does not change.
- R4: A write with bit 7 of sel_wdata set copies the live period into tick_count. Between such writes, tick_count holds its value whatever the word clocks do.
- R5: A write that changes the selected input clears the live period and tick_count to 0. This applies even when bit 7 is set in the same write.
- R6: Validity of each input depends on its own flags.
  - Input A is valid only while clk_ok_a and dat_ok_a are both 1.
  - Input B is valid only while clk_ok_b and dat_ok_b are both 1.
  - The flags of the unselected input have no effect.
  - While the selected input is invalid, rate_code and rate_hz are 0.
- R7: The snapped rate depends on t = tick_count and m = floor(28224000 / t).
  - The rate is the first entry in this list whose threshold m strictly exceeds, shown as threshold → rate (code): 184200 → 192000 (15), 152200 → 176400 (14), 112000 → 128000 (13), 92100 → 96000 (12), 76100 → 88200 (11), 56000 → 64000 (10), 46050 → 48000 (9), 38050 → 44100 (8), 28000 → 32000 (7), 23025 → 24000 (6), 19025 → 22050 (5), 14000 → 16000 (4), 11512 → 12000 (3), 9512 → 11025 (2), 7000 → 8000 (1).
  - If no threshold is exceeded, or if t = 0, rate and code are 0.
- R8: If the selected input has no rising edge for 1023 reference cycles, the live period becomes 0 and the counter saturates. Periods of 1023 cycles or more therefore read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 28.224 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wclk_a | input | 1 | Primary word clock (asynchronous) |
| wclk_b | input | 1 | Second word clock (asynchronous) |
| clk_ok_a | input | 1 | Primary input reports clock present |
| dat_ok_a | input | 1 | Primary input reports data present |
| clk_ok_b | input | 1 | Second input reports clock present |
| dat_ok_b | input | 1 | Second input reports data present |
| sel_we | input | 1 | Control write strobe, one cycle |
| sel_wdata | input | 8 | Control byte: bit 0 selects A, bit 1 selects B, bit 7 freezes the count |
| tick_count | output | 10 | Frozen period in reference ticks |
| rate_code | output | 4 | Snapped rate index, 0 means none |
| rate_hz | output | 18 | Snapped rate in Hz, 0 means none |

## Verification
The hardest conditions to reach from the ports are the exact tick counts on either side of each snapping bound. Each such count needs a word clock with that period in reference cycles, held steady long enough for a full period to be measured after the source is armed. The bench drives a cycle-exact word-clock generator in lockstep with the reference clock. It sweeps the period across the whole 10-bit range and also places periods on both sides of every reachable bound. Expected rates come from an integer division and the threshold list.

// File: rtl/wclk_rate_meter.sv
module wclk_rate_meter #(
  parameter int unsigned REF_HZ = 28224000,
  parameter int          CNT_W  = 10,
  parameter int          RATE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wclk_a,
  input  logic              wclk_b,
  input  logic              clk_ok_a,
  input  logic              dat_ok_a,
  input  logic              clk_ok_b,
  input  logic              dat_ok_b,
  input  logic              sel_we,
  input  logic [7:0]        sel_wdata,
  output logic [CNT_W-1:0]  tick_count,
  output logic [3:0]        rate_code,
  output logic [RATE_W-1:0] rate_hz
);
  localparam int NRATE = 15;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic int unsigned floor_hz(input int i);
    case (i)
      1: return 7000;    2: return 9512;    3: return 11512;
      4: return 14000;   5: return 19025;   6: return 23025;
      7: return 28000;   8: return 38050;   9: return 46050;
      10: return 56000;  11: return 76100;  12: return 92100;
      13: return 112000; 14: return 152200; 15: return 184200;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned std_hz(input int i);
    case (i)
      1: return 8000;    2: return 11025;   3: return 12000;
      4: return 16000;   5: return 22050;   6: return 24000;
      7: return 32000;   8: return 44100;   9: return 48000;
      10: return 64000;  11: return 88200;  12: return 96000;
      13: return 128000; 14: return 176400; 15: return 192000;
      default: return 0;
    endcase
  endfunction

  logic [2:0]       sync_a, sync_b;
  logic             sel_q;
  logic [CNT_W-1:0] cnt_q, period_q;
  logic             wr_sel, src_chg, edge_hit, armed, src_ok;
  logic [NRATE-1:0] hit;
  logic [3:0]       code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[1:0], wclk_a};
      sync_b <= {sync_b[1:0], wclk_b};
    end

  assign edge_hit = sel_q ? (sync_b[1] & ~sync_b[2]) : (sync_a[1] & ~sync_a[2]);
  assign wr_sel   = sel_wdata[0] ? 1'b0 : (sel_wdata[1] ? 1'b1 : sel_q);
  assign src_chg  = sel_we && (wr_sel != sel_q);
  assign armed    = (cnt_q != '0) && (cnt_q != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= 1'b0;
    else if (sel_we) sel_q <= wr_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q    <= '0;
      period_q <= '0;
    end else if (src_chg) begin
      cnt_q    <= '0;
      period_q <= '0;
    end else if (edge_hit) begin
      if (armed) period_q <= cnt_q;
      cnt_q <= CNT_W'(1);
    end else if (armed) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_MAX - 1'b1) period_q <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick_count <= '0;
    else if (src_chg) tick_count <= '0;
    else if (sel_we && sel_wdata[7]) tick_count <= period_q;

  genvar g;
  generate
    for (g = 1; g <= NRATE; g++) begin : g_bound
      localparam int unsigned BOUND = REF_HZ / (floor_hz(g) + 1);
      assign hit[g-1] = (tick_count != '0) &&
                        ({{(32-CNT_W){1'b0}}, tick_count} <= BOUND);
    end
  endgenerate

  assign src_ok = sel_q ? (clk_ok_b & dat_ok_b) : (clk_ok_a & dat_ok_a);

  always_comb begin
    code = '0;
    for (int i = 0; i < NRATE; i++)
      if (hit[i]) code = 4'(i + 1);
  end

  assign rate_code = src_ok ? code : 4'd0;
  assign rate_hz   = RATE_W'(std_hz(int'(rate_code)));

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(tick_count)); // R4
  AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg |=> (tick_count == '0)); // R5
  AST_CODE_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 4'd0) == (rate_hz == '0)); // R7
  AST_ZERO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && !(clk_ok_a && dat_ok_a)) |-> (rate_hz == '0)); // R6
  AST_NO_FULL_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    period_q != CNT_MAX); // R8
  AST_STALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |-> (period_q == '0)); // R8
endmodule

// File: tb/wclk_rate_meter_tb.sv
module wclk_rate_meter_tb;
  logic clk = 0, rst_n = 0;
  logic wclk_a = 0, wclk_b = 0;
  logic clk_ok_a = 1, dat_ok_a = 1, clk_ok_b = 0, dat_ok_b = 0;
  logic sel_we = 0;
  logic [7:0] sel_wdata = 0;
  logic [9:0] tick_count;
  logic [3:0] rate_code;
  logic [17:0] rate_hz;
  int checks = 0, errors = 0, pa = 0, pb = 0, pha = 0, phb = 0;
  bit done = 0;

  wclk_rate_meter u_dut (.*);

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (pa == 0) begin wclk_a <= 0; pha <= 0; end
    else begin pha <= (pha + 1 >= pa) ? 0 : pha + 1; wclk_a <= (pha < pa / 2); end
    if (pb == 0) begin wclk_b <= 0; phb <= 0; end
    else begin phb <= (phb + 1 >= pb) ? 0 : phb + 1; wclk_b <= (phb < pb / 2); end
  end

  function automatic int exp_code(input int t);
    int m;
    if (t == 0) return 0;
    m = 28224000 / t;
    if (m > 184200) return 15; if (m > 152200) return 14;
    if (m > 112000) return 13; if (m > 92100) return 12;
    if (m > 76100) return 11;  if (m > 56000) return 10;
    if (m > 46050) return 9;   if (m > 38050) return 8;
    if (m > 28000) return 7;   if (m > 23025) return 6;
    if (m > 19025) return 5;   if (m > 14000) return 4;
    if (m > 11512) return 3;   if (m > 9512) return 2;
    if (m > 7000) return 1;
    return 0;
  endfunction

  function automatic int code_hz(input int c);
    case (c)
      15: return 192000; 14: return 176400; 13: return 128000; 12: return 96000;
      11: return 88200;  10: return 64000;  9: return 48000;   8: return 44100;
      7: return 32000;   6: return 24000;   5: return 22050;   4: return 16000;
      3: return 12000;   2: return 11025;   1: return 8000;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk); sel_we = 1; sel_wdata = d;
    @(negedge clk); sel_we = 0; sel_wdata = 0;
  endtask

  task automatic check_rate(input string req, input int t, input bit ok);
    int c;
    c = ok ? exp_code(t) : 0;
    check(req, tick_count, t);
    check(req, rate_code, c);
    check(req, rate_hz, code_hz(c));
  endtask

  task automatic measure_a(input int p, input string req);
    pa = p;
    repeat (3 * p + 20) @(negedge clk);
    host_wr(8'h81);
    check_rate(req, p, 1);
  endtask

  initial begin
    int bnd[18] = '{153,154,185,186,251,252,306,307,370,371,503,504,612,613,741,742,1007,1008};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ticks", tick_count, 0);
    check("R1 code", rate_code, 0);
    check("R1 rate", rate_hz, 0);
    for (int p = 2; p <= 1022; p += 40) measure_a(p, "R2 R7 sweep");
    foreach (bnd[i]) measure_a(bnd[i], "R7 bound");
    // R6: flags of B ignored while A selected
    check("R6 other flags", rate_hz, code_hz(exp_code(1008)));
    clk_ok_a = 0; #1;
    check_rate("R6 no clock", 1008, 0);
    clk_ok_a = 1; dat_ok_a = 0; #1;
    check_rate("R6 no data", 1008, 0);
    dat_ok_a = 1; #1;
    check_rate("R6 restored", 1008, 1);
    // R4 freeze
    pa = 500;
    repeat (2000) @(negedge clk);
    check("R4 frozen", tick_count, 1008);
    // R5 / R3 switch to B
    pb = 300; clk_ok_b = 1; dat_ok_b = 1; clk_ok_a = 0;
    host_wr(8'h82);
    check("R5 clear on change", tick_count, 0);
    repeat (3 * 300 + 20) @(negedge clk);
    host_wr(8'h80);
    check_rate("R3 neither bit keeps B", 300, 1);
    host_wr(8'h00);
    check("R3 plain write no effect", tick_count, 300);
    clk_ok_a = 1;
    host_wr(8'h03);
    check("R3 both bits pick A", tick_count, 0);
    repeat (3 * 500 + 20) @(negedge clk);
    host_wr(8'h81);
    check_rate("R3 A after both", 500, 1);
    // R8 stall then R2 rearm
    pa = 0;
    repeat (1100) @(negedge clk);
    host_wr(8'h81);
    check_rate("R8 stall", 0, 1);
    measure_a(200, "R2 rearm");
    measure_a(1022, "R8 longest");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule